// File: doc/BRIEF.md
# TLB Entry Window Register File

This block is the software-facing register set through which a processor manages the entries of a translation lookaside buffer. Software never addresses an entry directly. It loads an index register and then reads or writes two window registers. The tag window maps onto a 32-bit tag word, and the data window maps onto a 64-bit data word held as two 32-bit halves. A process-ID register and a zone-protection register complete the set. A write-only search register hands an address to a separate associative lookup unit and loads the result into the index register.

Register accesses use a single port. Each access carries a register select, a read/write flag and an "extended" flag that reaches the upper half of the data word. Reads answer one cycle later. Whenever a cached translation may go stale, the block raises a one-cycle flush pulse: either a per-entry flush vector or a global flush strobe. A configuration input sets how much of the register set software may use.

Top module: `tlb_window_regs`

## Requirements
- R1: The register select encodes 0 as the data window (low data half), 1 as the tag window, 2 as the index register, 3 as the search register, 4 as the process ID and 5 as the zone register. Window accesses address the entry given by the low IDX_W bits of the index register.
- R2: A read of the tag window copies the selected entry's stored task ID into the process-ID register.
- R3: A write of the tag window does three things to the selected entry. It stores the current process ID as the entry's task ID. It sets the entry's valid state from bit 6 of the written value. If the entry was valid before the write, it raises that entry's bit alone in the flush vector on the following cycle.
- R4: With the extended flag set, the data window reaches the upper 32 bits of the data word. An extended access to any other register changes nothing, and an extended read of such a register returns zero.
- R5: Bit 31 of the index register is the miss flag and cannot be written by software. A software write changes only bits 30:0.
- R6: At access level 2 or above, a write of the search register emits a one-cycle search request. The request carries the written address with bits 9:0 cleared and the current privilege. A hit response loads the index register with the returned index and clears bit 31. A miss response sets bit 31 and leaves bits 30:0 unchanged.
- R7: Reads of the search register and of selects 6 and 7 return zero. Writes to selects 6 and 7 change nothing.
- R8: A process-ID write with a new value raises, on the following cycle, the flush-vector bit of every valid entry whose task ID is nonzero and equals the old process ID. A zone-register write with a new value raises the global flush strobe for one cycle. Writing the value already held raises neither.
- R9: At access level 0 every read returns zero and every write is ignored. At level 1, writes to the process ID, zone and search registers are ignored, while window and index writes still take effect.
- R10: After reset, all registers read zero and every entry reads as zero and invalid.
- R11: Each read access yields exactly one read-valid pulse with its data, one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level | input | 2 | Access level: 0 none, 1 restricted, 2 or 3 full |
| priv_user | input | 1 | Current privilege is user mode |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_ext | input | 1 | Extended (upper data half) access |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 32 | Write value |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| srch_req | output | 1 | Search request pulse |
| srch_addr | output | 32 | Search address, bits 9:0 cleared |
| srch_user | output | 1 | Privilege of the search |
| srch_done | input | 1 | Search response valid |
| srch_hit | input | 1 | Search hit |
| srch_idx | input | IDX_W | Index of the matching entry |
| flush_vec | output | ENTRIES | Per-entry flush pulse |
| flush_all | output | 1 | Global flush pulse |

## Verification
Read data, the search request and both flush outputs all appear one clock edge after the access that causes them. The bench drives each access on a falling edge and samples the outputs at the next falling edge. A read pushes its expected word into a queue, and a monitor pops that word on the falling edge where read-valid is high. A search result becomes visible in the index register on the edge after the response, so it is checked through a later read.

// File: rtl/tlbreg_pkg.sv
package tlbreg_pkg;
  localparam logic [2:0] SEL_DATA   = 3'd0;
  localparam logic [2:0] SEL_TAG    = 3'd1;
  localparam logic [2:0] SEL_INDEX  = 3'd2;
  localparam logic [2:0] SEL_SEARCH = 3'd3;
  localparam logic [2:0] SEL_PID    = 3'd4;
  localparam logic [2:0] SEL_ZONE   = 3'd5;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_REG,
    SRC_TAG,
    SRC_DLO,
    SRC_DHI
  } rd_src_e;
endpackage

// File: rtl/tlbreg_ram.sv
module tlbreg_ram #(
  parameter int W = 32,
  parameter int D = 64,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  // read-first single port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tlbreg_flush.sv
module tlbreg_flush #(
  parameter int N  = 64,
  parameter int TW = 8
) (
  input  logic [N-1:0]    vld,
  input  logic [N*TW-1:0] tid_flat,
  input  logic [TW-1:0]   key,
  output logic [N-1:0]    hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [TW-1:0] t;
    assign t      = tid_flat[g*TW +: TW];
    assign hit[g] = vld[g] && (t != '0) && (t == key);
  end
endmodule

// File: rtl/tlb_window_regs.sv
module tlb_window_regs
  import tlbreg_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int PID_W     = 8,
  parameter int VALID_BIT = 6,
  parameter int PAGE_LSB  = 10,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_level,
  input  logic               priv_user,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_ext,
  input  logic [2:0]         acc_sel,
  input  logic [31:0]        acc_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               srch_req,
  output logic [31:0]        srch_addr,
  output logic               srch_user,
  input  logic               srch_done,
  input  logic               srch_hit,
  input  logic [IDX_W-1:0]   srch_idx,
  output logic [ENTRIES-1:0] flush_vec,
  output logic               flush_all
);
  localparam logic [31:0] PAGE_MASK = ~((32'd1 << PAGE_LSB) - 32'd1);

  logic [31:0]        tlbx;
  logic [PID_W-1:0]   pid;
  logic [31:0]        zpr;
  logic [ENTRIES-1:0] vld;
  logic [PID_W-1:0]   tids [ENTRIES];
  logic [ENTRIES-1:0] seen_tag, seen_lo, seen_hi;
  rd_src_e            rd_src;
  logic [31:0]        rd_reg;
  logic               rd_seen;
  logic [31:0]        q_tag, q_lo, q_hi;
  logic [ENTRIES*PID_W-1:0] tid_flat;
  logic [ENTRIES-1:0] pid_hits;

  logic [IDX_W-1:0] idx;
  logic ok_base, do_wr, do_rd, full_wr;
  logic we_lo, we_hi, we_tag, wr_index, wr_search, wr_pid, wr_zone;

  assign idx      = tlbx[IDX_W-1:0];
  assign full_wr  = cfg_level[1];
  assign ok_base  = acc_valid && (cfg_level != 2'd0) && (!acc_ext || acc_sel == SEL_DATA);
  assign do_wr    = ok_base && acc_write;
  assign do_rd    = ok_base && !acc_write;
  assign we_lo    = do_wr && acc_sel == SEL_DATA && !acc_ext;
  assign we_hi    = do_wr && acc_sel == SEL_DATA && acc_ext;
  assign we_tag   = do_wr && acc_sel == SEL_TAG;
  assign wr_index = do_wr && acc_sel == SEL_INDEX;
  assign wr_search = do_wr && acc_sel == SEL_SEARCH && full_wr;
  assign wr_pid   = do_wr && acc_sel == SEL_PID && full_wr && (acc_wdata[PID_W-1:0] != pid);
  assign wr_zone  = do_wr && acc_sel == SEL_ZONE && full_wr && (acc_wdata != zpr);

  tlbreg_ram #(.W(32), .D(ENTRIES)) u_tag (
    .clk(clk), .we(we_tag), .addr(idx), .wdata(acc_wdata), .rdata(q_tag));
  tlbreg_ram #(.W(32), .D(ENTRIES)) u_dlo (
    .clk(clk), .we(we_lo), .addr(idx), .wdata(acc_wdata), .rdata(q_lo));
  tlbreg_ram #(.W(32), .D(ENTRIES)) u_dhi (
    .clk(clk), .we(we_hi), .addr(idx), .wdata(acc_wdata), .rdata(q_hi));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign tid_flat[g*PID_W +: PID_W] = tids[g];
  end

  tlbreg_flush #(.N(ENTRIES), .TW(PID_W)) u_flush (
    .vld(vld), .tid_flat(tid_flat), .key(pid), .hit(pid_hits));

  always_ff @(posedge clk) begin
    if (rst) begin
      tlbx      <= '0;
      pid       <= '0;
      zpr       <= '0;
      vld       <= '0;
      seen_tag  <= '0;
      seen_lo   <= '0;
      seen_hi   <= '0;
      for (int i = 0; i < ENTRIES; i++) tids[i] <= '0;
      rd_valid  <= 1'b0;
      rd_src    <= SRC_ZERO;
      rd_reg    <= '0;
      rd_seen   <= 1'b0;
      flush_vec <= '0;
      flush_all <= 1'b0;
      srch_req  <= 1'b0;
      srch_addr <= '0;
      srch_user <= 1'b0;
    end else begin
      rd_valid  <= acc_valid && !acc_write;
      rd_src    <= SRC_ZERO;
      flush_vec <= '0;
      flush_all <= 1'b0;
      srch_req  <= 1'b0;

      if (do_rd) begin
        case (acc_sel)
          SEL_DATA: begin
            rd_src  <= acc_ext ? SRC_DHI : SRC_DLO;
            rd_seen <= acc_ext ? seen_hi[idx] : seen_lo[idx];
          end
          SEL_TAG: begin
            rd_src  <= SRC_TAG;
            rd_seen <= seen_tag[idx];
            pid     <= tids[idx];
          end
          SEL_INDEX: begin rd_src <= SRC_REG; rd_reg <= tlbx; end
          SEL_PID:   begin rd_src <= SRC_REG; rd_reg <= {{(32-PID_W){1'b0}}, pid}; end
          SEL_ZONE:  begin rd_src <= SRC_REG; rd_reg <= zpr; end
          default:   rd_src <= SRC_ZERO;
        endcase
      end

      if (we_lo) seen_lo[idx] <= 1'b1;
      if (we_hi) seen_hi[idx] <= 1'b1;
      if (we_tag) begin
        seen_tag[idx] <= 1'b1;
        tids[idx]     <= pid;
        vld[idx]      <= acc_wdata[VALID_BIT];
        if (vld[idx]) flush_vec[idx] <= 1'b1;
      end

      if (wr_pid) begin
        flush_vec <= pid_hits;
        pid       <= acc_wdata[PID_W-1:0];
      end

      if (wr_zone) begin
        flush_all <= 1'b1;
        zpr       <= acc_wdata;
      end

      if (wr_search) begin
        srch_req  <= 1'b1;
        srch_addr <= acc_wdata & PAGE_MASK;
        srch_user <= priv_user;
      end

      // a search response takes priority over a software index write
      if (srch_done) begin
        if (srch_hit) tlbx <= {{(32-IDX_W){1'b0}}, srch_idx};
        else          tlbx[31] <= 1'b1;
      end else if (wr_index) begin
        tlbx[30:0] <= acc_wdata[30:0];
      end
    end
  end

  always_comb begin
    case (rd_src)
      SRC_REG: rd_data = rd_reg;
      SRC_TAG: rd_data = rd_seen ? q_tag : 32'd0;
      SRC_DLO: rd_data = rd_seen ? q_lo : 32'd0;
      SRC_DHI: rd_data = rd_seen ? q_hi : 32'd0;
      default: rd_data = 32'd0;
    endcase
  end

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write));

  // R8
  zone_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all |-> $past(acc_valid && acc_write && !acc_ext && acc_sel == SEL_ZONE && cfg_level[1]));

  // R5
  miss_bit_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_sel == SEL_INDEX && !srch_done) |=> $stable(tlbx[31]));

  // R6
  search_req_chk: assert property (@(posedge clk) disable iff (rst)
    srch_req |-> $past(acc_valid && acc_write && !acc_ext && acc_sel == SEL_SEARCH && cfg_level[1]));

  // R9
  level0_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(cfg_level == 2'd0)) |-> (rd_data == 32'd0));

  // R3
  tag_flush_single_chk: assert property (@(posedge clk) disable iff (rst)
    ((flush_vec != '0) && !$past(acc_valid && acc_write && acc_sel == SEL_PID))
      |-> ($countones(flush_vec) == 1));
endmodule

// File: tb/tlb_window_regs_tb.sv
module tlb_window_regs_tb;
  localparam int ENTRIES = 64;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [2:0] S_DATA = 3'd0, S_TAG = 3'd1, S_INDEX = 3'd2,
                         S_SEARCH = 3'd3, S_PID = 3'd4, S_ZONE = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_level = 2'd3;
  logic priv_user = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_ext = 1'b0;
  logic [2:0] acc_sel = '0;
  logic [31:0] acc_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic srch_req, srch_user;
  logic [31:0] srch_addr;
  logic srch_done = 1'b0, srch_hit = 1'b0;
  logic [IDX_W-1:0] srch_idx = '0;
  logic [ENTRIES-1:0] flush_vec;
  logic flush_all;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  tlb_window_regs #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .priv_user(priv_user),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_ext(acc_ext),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .srch_req(srch_req), .srch_addr(srch_addr),
    .srch_user(srch_user), .srch_done(srch_done), .srch_hit(srch_hit),
    .srch_idx(srch_idx), .flush_vec(flush_vec), .flush_all(flush_all));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word per read-valid pulse
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected read", 64'(rd_data), 64'hDEAD);
      else check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
    end
  end

  task automatic acc(input bit wr, input bit ext, input logic [2:0] sel, input logic [31:0] wd);
    acc_valid = 1'b1; acc_write = wr; acc_ext = ext; acc_sel = sel; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_ext = 1'b0;
  endtask

  task automatic rd(input bit ext, input logic [2:0] sel, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(1'b0, ext, sel, 32'd0);
  endtask

  task automatic wr(input bit ext, input logic [2:0] sel, input logic [31:0] wd);
    acc(1'b1, ext, sel, wd);
  endtask

  task automatic respond(input bit hit, input logic [IDX_W-1:0] id);
    srch_done = 1'b1; srch_hit = hit; srch_idx = id;
    @(negedge clk);
    srch_done = 1'b0; srch_hit = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    check("R10 flush_vec", 64'(flush_vec), 64'd0);
    check("R10 srch_req", 64'(srch_req), 64'd0);
    rd(0, S_INDEX, 32'd0, "R10 index");
    check("R11 rd_valid pulse", 64'(rd_valid), 64'd1);
    rd(0, S_PID, 32'd0, "R10 pid");
    rd(0, S_ZONE, 32'd0, "R10 zone");
    rd(0, S_DATA, 32'd0, "R10 data lo");
    rd(1, S_DATA, 32'd0, "R10 data hi");
    rd(0, S_TAG, 32'd0, "R10 tag");
    @(negedge clk);
    check("R11 rd_valid idle", 64'(rd_valid), 64'd0);

    // fill entry 5
    wr(0, S_INDEX, 32'd5);
    wr(0, S_PID, 32'h23);
    check("R8 no valid entries", 64'(flush_vec), 64'd0);
    wr(0, S_TAG, 32'h1234_5440);
    check("R3 no flush of invalid entry", 64'(flush_vec), 64'd0);
    wr(0, S_DATA, 32'hAAAA_5555);
    wr(1, S_DATA, 32'hBBBB_6666);
    rd(0, S_DATA, 32'hAAAA_5555, "R1 data lo");
    rd(1, S_DATA, 32'hBBBB_6666, "R4 data hi");
    rd(0, S_TAG, 32'h1234_5440, "R1 tag");

    // pid change flushes entries owned by old pid
    wr(0, S_PID, 32'h00);
    check("R8 pid flush", 64'(flush_vec), 64'(64'd1 << 5));
    rd(0, S_PID, 32'h0, "R8 pid new");
    rd(0, S_TAG, 32'h1234_5440, "R2 tag");
    rd(0, S_PID, 32'h23, "R2 pid copied");

    // rewrite valid entry
    wr(0, S_TAG, 32'h0);
    check("R3 flush onehot", 64'(flush_vec), 64'(64'd1 << 5));
    wr(0, S_PID, 32'h00);
    check("R8 invalid not flushed", 64'(flush_vec), 64'd0);
    rd(0, S_TAG, 32'h0, "R3 tag cleared");
    rd(0, S_PID, 32'h23, "R3 tid stored");

    // extended access elsewhere ignored
    wr(1, S_TAG, 32'hFFFF_FFFF);
    check("R4 no flush", 64'(flush_vec), 64'd0);
    rd(0, S_TAG, 32'h0, "R4 ext tag ignored");
    rd(1, S_INDEX, 32'h0, "R4 ext read zero");

    // index bit 31 read-only
    wr(0, S_INDEX, 32'hFFFF_FFFF);
    rd(0, S_INDEX, 32'h7FFF_FFFF, "R5 bit31 ro");

    // search
    priv_user = 1'b1;
    wr(0, S_SEARCH, 32'h4567_89AB);
    check("R6 req", 64'(srch_req), 64'd1);
    check("R6 addr", 64'(srch_addr), 64'h4567_8800);
    check("R6 user", 64'(srch_user), 64'd1);
    respond(1'b1, 6'd9);
    rd(0, S_INDEX, 32'd9, "R6 hit");
    wr(0, S_SEARCH, 32'h0000_1000);
    respond(1'b0, 6'd0);
    rd(0, S_INDEX, 32'h8000_0009, "R6 miss");
    wr(0, S_INDEX, 32'd3);
    rd(0, S_INDEX, 32'h8000_0003, "R5 flag kept");

    // unreadable and unknown
    rd(0, S_SEARCH, 32'h0, "R7 search read");
    rd(0, 3'd7, 32'h0, "R7 sel7 read");
    wr(0, 3'd6, 32'h55);
    rd(0, S_INDEX, 32'h8000_0003, "R7 sel6 write");
    rd(0, 3'd6, 32'h0, "R7 sel6 read");

    // zone
    wr(0, S_ZONE, 32'hC000_0000);
    check("R8 zone flush", 64'(flush_all), 64'd1);
    rd(0, S_ZONE, 32'hC000_0000, "R8 zone value");
    wr(0, S_ZONE, 32'hC000_0000);
    check("R8 zone same", 64'(flush_all), 64'd0);

    // level 1
    cfg_level = 2'd1;
    wr(0, S_PID, 32'h77);
    rd(0, S_PID, 32'h23, "R9 l1 pid");
    wr(0, S_ZONE, 32'h0);
    check("R9 l1 zone flush", 64'(flush_all), 64'd0);
    rd(0, S_ZONE, 32'hC000_0000, "R9 l1 zone");
    wr(0, S_SEARCH, 32'h1000);
    check("R9 l1 search", 64'(srch_req), 64'd0);
    wr(0, S_INDEX, 32'd4);
    rd(0, S_INDEX, 32'h8000_0004, "R9 l1 index");

    // level 0
    cfg_level = 2'd0;
    rd(0, S_INDEX, 32'h0, "R9 l0 read");
    wr(0, S_INDEX, 32'd1);
    cfg_level = 2'd3;
    rd(0, S_INDEX, 32'h8000_0004, "R9 l0 write");

    repeat (3) @(negedge clk);
    check("R11 queue drained", 64'(exp_q.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule